// File: doc/BRIEF.md
# Synchronous Burst Static RAM with Selectable Read Latency

This block is a synthesizable behavioural model of a synchronous burst static RAM, sized down to 256 words of 18 bits split into two 9-bit byte lanes. On each rising clock edge it samples the address, the write data, three chip enables, two equivalent address strobes, a burst-advance input and the write controls. A strobe on a selected cycle loads a new burst start address. After that, each advance steps a 2-bit counter that supplies the two low address bits, in either linear or interleaved order.

Two parameters fix the configuration. One chooses the burst order and the other chooses the read latency. The defaults give interleaved order and a registered output path, so a read burst is timed 3-1-1-1. The flow-through variant bypasses the output register and times a read burst 2-1-1-1. Read and write data use separate ports. An asynchronous output enable and a sleep input gate the read port. Sleep also freezes all accesses, and the stored contents are kept.

Top module: `burst_sram`

## Requirements
- R1: A strobe (`strobe_host` or `strobe_ctrl`, both active high) on a selected, awake edge loads `addr` as the burst start, resets the step count to 0, and accesses `addr` on that same edge.
- R2: The step count advances only on an edge with `advance` high while a burst is active. An edge with no strobe and no advance makes no access and produces no read data.
- R3: With `ORDER_LINEAR`=0 (the default), the low two address bits of step n are the start low bits XOR n. Example: start 1 gives 1,0,3,2.
- R4: With `ORDER_LINEAR`=1, the low two address bits of step n are (start low bits + n) mod 4. Example: start 1 gives 1,2,3,0. The upper address bits stay fixed during the burst.
- R5: With `REG_OUT`=1 (the default), data for a read accessed on edge k appears on `rdata` with `rdata_drv`=1 after edge k+1.
- R6: With `REG_OUT`=0, data for a read accessed on edge k appears after edge k itself.
- R7: With `wr_all` high, an access writes both lanes, whatever `wr_byte` and `byte_sel` are.
- R8: With `wr_all` low and `wr_byte` high, only the lanes whose `byte_sel` bit is 1 are written. Bit 0 selects data bits 8:0 and bit 1 selects bits 17:9. A write access never produces read data.
- R9: A new strobe may arrive on every edge, and each one starts an access with no stall.
- R10: While `out_en_n` is high, `rdata` is 0 and `rdata_drv` is 0, with no clock edge needed. When it returns low, the held data reappears.
- R11: A cycle is selected only when `en_a_n`=0, `en_b`=1 and `en_c_n`=0. On a deselected edge a strobe loads nothing, performs no read or write, and ends any active burst.
- R12: While `sleep` is high, no edge reads or writes, and the outputs are forced to 0 at once. Stored data is retained. Normal operation resumes on the first edge with `sleep` low.
- R13: After reset, `rdata` and `rdata_drv` are 0 and no burst is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low reset |
| addr | input | 8 | Word address |
| strobe_host | input | 1 | Address strobe, processor side |
| strobe_ctrl | input | 1 | Address strobe, controller side |
| advance | input | 1 | Step the burst counter |
| en_a_n | input | 1 | Chip enable, active low |
| en_b | input | 1 | Chip enable, active high |
| en_c_n | input | 1 | Chip enable, active low |
| wr_all | input | 1 | Write every lane |
| wr_byte | input | 1 | Write lanes chosen by byte_sel |
| byte_sel | input | 2 | Lane select for byte writes |
| wdata | input | 18 | Write data |
| out_en_n | input | 1 | Asynchronous output enable, active low |
| sleep | input | 1 | Low-power hold |
| rdata | output | 18 | Read data, 0 when not driven |
| rdata_drv | output | 1 | Read port is driving valid data |

## Verification
The bench drives one stimulus set into two copies: the default one (interleaved, registered) and a linear, flow-through one. For the same access it therefore expects the same word one edge apart: after edge k from the flow-through copy, and after edge k+1 from the registered copy. Every input changes 1 ns after a rising edge, and the outputs are sampled at that moment too, so each sample reflects exactly the edges counted so far. Output-enable and sleep gating are checked 1 ns after the level change with no edge in between, which shows that the gating does not depend on the clock.

// File: rtl/bsram_pkg.sv
package bsram_pkg;

    // Low two address bits for burst step 'step' from start 'start'.
    function automatic logic [1:0] burst_low(input logic [1:0] start,
                                             input logic [1:0] step,
                                             input bit         linear);
        logic [1:0] r;
        if (linear) r = start + step;
        else        r = start ^ step;
        return r;
    endfunction

endpackage

// File: rtl/bsram_addr_ctl.sv
module bsram_addr_ctl
    import bsram_pkg::*;
#(
    parameter int ADDR_W       = 8,
    parameter int LANES        = 2,
    parameter bit ORDER_LINEAR = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              load,
    input  logic              advance,
    input  logic              selected,
    input  logic              sleep,
    input  logic              wr_all,
    input  logic              wr_byte,
    input  logic [LANES-1:0]  byte_sel,
    output logic [ADDR_W-1:0] acc_addr,
    output logic [LANES-1:0]  wr_lanes,
    output logic [ADDR_W-1:0] rd_addr_q,
    output logic              rd_v_q
);

    typedef struct packed {
        logic [ADDR_W-1:0] base;
        logic [1:0]        cnt;
        logic              active;
        logic [ADDR_W-1:0] rd_addr;
        logic              rd_v;
    } ctl_t;

    ctl_t st_d, st_q;
    logic acc_go;
    logic is_wr;
    logic [1:0] step_d;
    logic [LANES-1:0] lane_mask;

    always_comb begin
        st_d     = st_q;
        st_d.rd_v = 1'b0;
        acc_go   = 1'b0;
        acc_addr = addr;
        step_d   = st_q.cnt + 2'd1;
        is_wr    = wr_all | wr_byte;
        lane_mask = wr_all ? {LANES{1'b1}} : byte_sel;

        if (sleep) begin
            st_d.active = 1'b0;
        end else if (load && selected) begin
            st_d.base   = addr;
            st_d.cnt    = 2'd0;
            st_d.active = 1'b1;
            acc_go      = 1'b1;
            acc_addr    = addr;
        end else if (load) begin
            st_d.active = 1'b0;
        end else if (advance && st_q.active) begin
            st_d.cnt = step_d;
            acc_go   = 1'b1;
            acc_addr = {st_q.base[ADDR_W-1:2],
                        burst_low(st_q.base[1:0], step_d, ORDER_LINEAR)};
        end

        wr_lanes = (acc_go && is_wr) ? lane_mask : '0;
        if (acc_go && !is_wr) begin
            st_d.rd_v    = 1'b1;
            st_d.rd_addr = acc_addr;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rd_addr_q = st_q.rd_addr;
    assign rd_v_q    = st_q.rd_v;

    AST_STEP_ON_ADV: assert property (@(posedge clk) disable iff (!rst_n)
        (!sleep && !load && advance && st_q.active)
        |=> (st_q.cnt == $past(st_q.cnt) + 2'd1)); // R2
    AST_HOLD_NO_ADV: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !advance) |=> ($stable(st_q.cnt) && !rd_v_q)); // R2
    AST_DESEL_NO_ACC: assert property (@(posedge clk) disable iff (!rst_n)
        (!sleep && load && !selected) |=> (!rd_v_q && !st_q.active)); // R11
    AST_SLEEP_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
        sleep |=> !rd_v_q); // R12
    AST_SLEEP_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        sleep |-> (wr_lanes == '0)); // R12

endmodule

// File: rtl/bsram_array.sv
module bsram_array #(
    parameter int ADDR_W = 8,
    parameter int LANE_W = 9,
    parameter int LANES  = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [LANES-1:0]          wr_lanes,
    input  logic [ADDR_W-1:0]         wr_addr,
    input  logic [LANES*LANE_W-1:0]   wdata,
    input  logic [ADDR_W-1:0]         rd_addr,
    output logic [LANES*LANE_W-1:0]   rd_data
);

    localparam int DEPTH = 1 << ADDR_W;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] mem_q [DEPTH];

        always_ff @(posedge clk) begin
            if (wr_lanes[g]) mem_q[wr_addr] <= wdata[g*LANE_W +: LANE_W];
        end

        assign rd_data[g*LANE_W +: LANE_W] = mem_q[rd_addr];
    end

    AST_WR_ADDR_KNOWN: assert property (@(posedge clk) disable iff (!rst_n)
        (|wr_lanes) |-> !$isunknown(wr_addr)); // R8

endmodule

// File: rtl/bsram_out_path.sv
module bsram_out_path #(
    parameter int DATA_W  = 18,
    parameter bit REG_OUT = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sleep,
    input  logic              out_en_n,
    input  logic              rd_v,
    input  logic [DATA_W-1:0] arr_data,
    output logic [DATA_W-1:0] rdata,
    output logic              rdata_drv
);

    logic              stage_v;
    logic [DATA_W-1:0] stage_data;

    if (REG_OUT) begin : g_registered
        typedef struct packed {
            logic              v;
            logic [DATA_W-1:0] data;
        } stage_t;

        stage_t stage_d, stage_q;

        always_comb begin
            stage_d.v    = rd_v & ~sleep;
            stage_d.data = rd_v ? arr_data : '0;
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q <= '0;
            else        stage_q <= stage_d;
        end

        assign stage_v    = stage_q.v;
        assign stage_data = stage_q.data;
    end else begin : g_flow
        assign stage_v    = rd_v;
        assign stage_data = arr_data;
    end

    assign rdata_drv = stage_v & ~out_en_n & ~sleep;
    assign rdata     = rdata_drv ? stage_data : '0;

    AST_OE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        out_en_n |-> (!rdata_drv && rdata == '0)); // R10
    AST_SLEEP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        sleep |-> (!rdata_drv && rdata == '0)); // R12

endmodule

// File: rtl/burst_sram.sv
module burst_sram #(
    parameter int ADDR_W       = 8,
    parameter int LANE_W       = 9,
    parameter int LANES        = 2,
    parameter bit ORDER_LINEAR = 1'b0,
    parameter bit REG_OUT      = 1'b1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [ADDR_W-1:0]       addr,
    input  logic                    strobe_host,
    input  logic                    strobe_ctrl,
    input  logic                    advance,
    input  logic                    en_a_n,
    input  logic                    en_b,
    input  logic                    en_c_n,
    input  logic                    wr_all,
    input  logic                    wr_byte,
    input  logic [LANES-1:0]        byte_sel,
    input  logic [LANES*LANE_W-1:0] wdata,
    input  logic                    out_en_n,
    input  logic                    sleep,
    output logic [LANES*LANE_W-1:0] rdata,
    output logic                    rdata_drv
);

    localparam int DATA_W = LANES * LANE_W;

    logic              load;
    logic              selected;
    logic [ADDR_W-1:0] acc_addr;
    logic [LANES-1:0]  wr_lanes;
    logic [ADDR_W-1:0] rd_addr_q;
    logic              rd_v_q;
    logic [DATA_W-1:0] arr_data;

    assign load     = strobe_host | strobe_ctrl;
    assign selected = ~en_a_n & en_b & ~en_c_n;

    bsram_addr_ctl #(
        .ADDR_W(ADDR_W), .LANES(LANES), .ORDER_LINEAR(ORDER_LINEAR)
    ) u_ctl (
        .clk(clk), .rst_n(rst_n), .addr(addr), .load(load),
        .advance(advance), .selected(selected), .sleep(sleep),
        .wr_all(wr_all), .wr_byte(wr_byte), .byte_sel(byte_sel),
        .acc_addr(acc_addr), .wr_lanes(wr_lanes),
        .rd_addr_q(rd_addr_q), .rd_v_q(rd_v_q)
    );

    bsram_array #(
        .ADDR_W(ADDR_W), .LANE_W(LANE_W), .LANES(LANES)
    ) u_array (
        .clk(clk), .rst_n(rst_n), .wr_lanes(wr_lanes), .wr_addr(acc_addr),
        .wdata(wdata), .rd_addr(rd_addr_q), .rd_data(arr_data)
    );

    bsram_out_path #(
        .DATA_W(DATA_W), .REG_OUT(REG_OUT)
    ) u_out (
        .clk(clk), .rst_n(rst_n), .sleep(sleep), .out_en_n(out_en_n),
        .rd_v(rd_v_q), .arr_data(arr_data),
        .rdata(rdata), .rdata_drv(rdata_drv)
    );

    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |-> (!rdata_drv && rdata == '0)); // R13

endmodule

// File: tb/burst_sram_test.sv
module burst_sram_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  addr = '0;
    logic        strobe_host = 1'b0, strobe_ctrl = 1'b0, advance = 1'b0;
    logic        en_a_n = 1'b0, en_b = 1'b1, en_c_n = 1'b0;
    logic        wr_all = 1'b0, wr_byte = 1'b0;
    logic [1:0]  byte_sel = '0;
    logic [17:0] wdata = '0;
    logic        out_en_n = 1'b0, sleep = 1'b0;
    logic [17:0] rd_p, rd_f;
    logic        drv_p, drv_f;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    localparam logic [18:0] NONE = 19'h0;

    always #4 clk = ~clk;

    // default: interleaved order, registered output
    burst_sram uut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .strobe_host(strobe_host),
        .strobe_ctrl(strobe_ctrl), .advance(advance), .en_a_n(en_a_n),
        .en_b(en_b), .en_c_n(en_c_n), .wr_all(wr_all), .wr_byte(wr_byte),
        .byte_sel(byte_sel), .wdata(wdata), .out_en_n(out_en_n),
        .sleep(sleep), .rdata(rd_p), .rdata_drv(drv_p)
    );

    // linear order, flow-through output
    burst_sram #(.ORDER_LINEAR(1'b1), .REG_OUT(1'b0)) uut_lf (
        .clk(clk), .rst_n(rst_n), .addr(addr), .strobe_host(strobe_host),
        .strobe_ctrl(strobe_ctrl), .advance(advance), .en_a_n(en_a_n),
        .en_b(en_b), .en_c_n(en_c_n), .wr_all(wr_all), .wr_byte(wr_byte),
        .byte_sel(byte_sel), .wdata(wdata), .out_en_n(out_en_n),
        .sleep(sleep), .rdata(rd_f), .rdata_drv(drv_f)
    );

    function automatic logic [17:0] pat(input logic [7:0] a);
        return {1'b1, a, 1'b0, ~a};
    endfunction

    function automatic logic [18:0] on(input logic [17:0] d);
        return {1'b1, d};
    endfunction

    task automatic chk(input string tag, input logic [18:0] got, input logic [18:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic idle();
        strobe_host = 1'b0; strobe_ctrl = 1'b0; advance = 1'b0;
        wr_all = 1'b0; wr_byte = 1'b0; byte_sel = '0;
        en_a_n = 1'b0; en_b = 1'b1; en_c_n = 1'b0;
    endtask

    task automatic rd_load(input logic [7:0] a, input bit use_ctrl);
        idle();
        addr = a;
        if (use_ctrl) strobe_ctrl = 1'b1;
        else          strobe_host = 1'b1;
    endtask

    task automatic t_reset();
        chk("R13 reset registered", {drv_p, rd_p}, NONE);
        chk("R13 reset flow", {drv_f, rd_f}, NONE);
    endtask

    task automatic t_fill();
        for (int a = 0; a < 32; a++) begin
            idle();
            strobe_host = 1'b1; addr = 8'(a);
            wr_all = 1'b1; wr_byte = 1'b1; byte_sel = 2'b00;
            wdata = pat(8'(a));
            step();
            if (a == 0 || a == 31) chk("R8 write gives no read data", {drv_f, rd_f}, NONE);
        end
        idle();
        step();
        chk("R7 R9 global write then idle", {drv_p, rd_p}, NONE);
    endtask

    task automatic t_back2back();
        for (int i = 0; i < 6; i++) begin
            rd_load(8'(i), i[0]);
            step();
            chk("R6 R9 R1 flow read", {drv_f, rd_f}, on(pat(8'(i))));
            if (i > 0) chk("R5 R9 registered read", {drv_p, rd_p}, on(pat(8'(i - 1))));
            else       chk("R5 registered not yet", {drv_p, rd_p}, NONE);
        end
        idle();
        step();
        chk("R5 last registered", {drv_p, rd_p}, on(pat(8'd5)));
        chk("R2 flow idle", {drv_f, rd_f}, NONE);
    endtask

    task automatic t_burst();
        logic [7:0] lin [4] = '{8'h11, 8'h12, 8'h13, 8'h10};
        logic [7:0] itl [4] = '{8'h11, 8'h10, 8'h13, 8'h12};
        rd_load(8'h11, 1'b1);
        step();
        chk("R4 linear beat0", {drv_f, rd_f}, on(pat(lin[0])));
        for (int j = 1; j < 4; j++) begin
            idle(); advance = 1'b1;
            step();
            chk("R4 linear beat", {drv_f, rd_f}, on(pat(lin[j])));
            chk("R3 interleaved beat", {drv_p, rd_p}, on(pat(itl[j - 1])));
        end
        idle();
        step();
        chk("R2 no advance no data", {drv_f, rd_f}, NONE);
        chk("R3 interleaved last", {drv_p, rd_p}, on(pat(itl[3])));
        step();
        chk("R2 registered drains", {drv_p, rd_p}, NONE);
    endtask

    task automatic t_hold();
        rd_load(8'h17, 1'b0);
        step();
        chk("R1 host strobe load", {drv_f, rd_f}, on(pat(8'h17)));
        idle();
        step();
        chk("R2 held counter idle", {drv_f, rd_f}, NONE);
        chk("R5 start word", {drv_p, rd_p}, on(pat(8'h17)));
        idle(); advance = 1'b1;
        step();
        chk("R4 linear step after gap", {drv_f, rd_f}, on(pat(8'h14)));
        chk("R2 registered idle gap", {drv_p, rd_p}, NONE);
        idle();
        step();
        chk("R3 interleaved step after gap", {drv_p, rd_p}, on(pat(8'h16)));
    endtask

    task automatic t_bytes();
        logic [17:0] p5 = pat(8'h05);
        logic [17:0] p6 = pat(8'h06);
        idle(); strobe_host = 1'b1; addr = 8'h05;
        wr_byte = 1'b1; byte_sel = 2'b10; wdata = 18'h3FFFF;
        step();
        chk("R8 byte write no read data", {drv_f, rd_f}, NONE);
        idle(); strobe_host = 1'b1; addr = 8'h06;
        wr_byte = 1'b1; byte_sel = 2'b01; wdata = 18'h0;
        step();
        idle(); strobe_host = 1'b1; addr = 8'h07;
        wr_byte = 1'b1; byte_sel = 2'b00; wdata = 18'h0;
        step();
        rd_load(8'h05, 1'b0); step();
        chk("R8 upper lane only", {drv_f, rd_f}, on({9'h1FF, p5[8:0]}));
        rd_load(8'h06, 1'b0); step();
        chk("R8 lower lane only", {drv_f, rd_f}, on({p6[17:9], 9'h000}));
        rd_load(8'h07, 1'b0); step();
        chk("R8 no lane selected", {drv_f, rd_f}, on(pat(8'h07)));
        idle(); step();
    endtask

    task automatic t_oe();
        rd_load(8'h03, 1'b0); step();
        idle(); step();
        chk("R5 before oe", {drv_p, rd_p}, on(pat(8'h03)));
        out_en_n = 1'b1; #1;
        chk("R10 oe off registered", {drv_p, rd_p}, NONE);
        out_en_n = 1'b0; #1;
        chk("R10 oe back registered", {drv_p, rd_p}, on(pat(8'h03)));
        rd_load(8'h09, 1'b1); step();
        out_en_n = 1'b1; #1;
        chk("R10 oe off flow", {drv_f, rd_f}, NONE);
        out_en_n = 1'b0; #1;
        chk("R10 oe back flow", {drv_f, rd_f}, on(pat(8'h09)));
    endtask

    task automatic t_desel();
        rd_load(8'h02, 1'b0); en_b = 1'b0;
        step();
        chk("R11 deselected strobe", {drv_f, rd_f}, NONE);
        idle(); advance = 1'b1;
        step();
        chk("R11 burst ended flow", {drv_f, rd_f}, NONE);
        chk("R11 deselect registered", {drv_p, rd_p}, NONE);
        idle(); en_a_n = 1'b1; strobe_host = 1'b1; addr = 8'h02;
        wr_all = 1'b1; wdata = 18'h0;
        step();
        idle(); en_c_n = 1'b1; strobe_ctrl = 1'b1; addr = 8'h02;
        wr_all = 1'b1; wdata = 18'h0;
        step();
        rd_load(8'h02, 1'b0); step();
        chk("R11 deselected write ignored", {drv_f, rd_f}, on(pat(8'h02)));
        idle(); step();
    endtask

    task automatic t_sleep();
        rd_load(8'h01, 1'b0); step();
        chk("R1 read before sleep", {drv_f, rd_f}, on(pat(8'h01)));
        idle(); sleep = 1'b1; #1;
        chk("R12 forced quiet", {drv_f, rd_f}, NONE);
        strobe_host = 1'b1; addr = 8'h04; wr_all = 1'b1; wdata = 18'h0;
        step();
        chk("R12 sleep flow quiet", {drv_f, rd_f}, NONE);
        chk("R12 sleep registered quiet", {drv_p, rd_p}, NONE);
        rd_load(8'h04, 1'b1); sleep = 1'b1;
        step();
        chk("R12 sleep read ignored", {drv_f, rd_f}, NONE);
        sleep = 1'b0;
        rd_load(8'h04, 1'b0);
        step();
        chk("R12 resume and retained", {drv_f, rd_f}, on(pat(8'h04)));
        idle(); step();
        chk("R12 resume registered", {drv_p, rd_p}, on(pat(8'h04)));
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        t_reset();
        rst_n = 1'b1;
        step();
        t_reset();
        t_fill();
        t_back2back();
        t_burst();
        t_hold();
        t_bytes();
        t_oe();
        t_desel();
        t_sleep();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_run++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule